// File: doc/BRIEF.md
# Floating Operand Effective-Address Sequencer

This block works out where a floating-point or long-integer operand lives, for a 16-bit minicomputer. It takes the operand's 3-bit addressing mode, its 3-bit register number, the value of that register, the program counter, the current single/double precision setting and a long-integer flag. For modes that need a word from memory (an index displacement or a pointer), a small state machine issues reads over a single-request, valid-response memory port. When the operand's location is known, the block pulses `done` and presents the operand address. It also reports whether the operand is a direct register or a short immediate, and gives the register update (index and new value) that the addressing mode implies.

Direct register operands need no memory access. Immediate operands taken through the program counter are short: only one 16-bit word is consumed. The arithmetic unit using this block zero-fills the low half of the operand. Register and mode combinations with no meaning raise a one-cycle `illegal` strobe instead of `done`. The block computes only addresses. The arithmetic, memory management and fault handling belong to other blocks.

Top module: `fop_ea_seq`

## Requirements
- R1: After reset, and after a reset that lands mid-operation, `done`, `illegal`, `mem_req` and `wb_en` are low.
- R2: Mode 0 with a legal register gives `done` one cycle after `start`, with `opnd_direct`=1, `opnd_addr`=0, no memory request and no register write.
- R3: Mode 2 on a register other than the PC (register 7) gives `opnd_addr` = register value. The same register is written with value+4 in single mode (`dbl_mode`=0) or value+8 in double mode.
- R4: For a float operand (`long_op`=0) with register 7 in modes 1, 2 or 3, `opnd_imm`=1 and the PC is written with PC+2. In modes 1 and 2 the address is the PC. In mode 3 the address is the word read at the PC.
- R5: Modes 4 and 5 first subtract 4 (single) or 8 (double) from the register and write that value back. Mode 4 uses it as the address. Mode 5 reads a pointer word at it and uses that word as the address.
- R6: Modes 6 and 7 read a displacement word at the PC and write PC+2 to register 7. The address is displacement + register, where register 7 contributes PC+2. Mode 7 then reads a pointer word at that sum and uses it as the address.
- R7: Mode 3 on a non-PC register reads a pointer word at the register value, uses it as the address, and writes the register back with value+4 (single) or value+8 (double).
- R8: With `long_op`=1, modes 2 to 5 step the register by 4 whatever `dbl_mode` is. With register 7 such operands are not immediates: `opnd_imm`=0 and the step is 4.
- R9: `mem_req` is high for one cycle per read, and the block waits for `mem_valid` before going on. `done` lasts one cycle. `wb_en` is only ever high together with `done`. The number of reads is 0, 1 or 2, matching the mode.
- R10: Mode 0 with register 6 or 7 for a float operand, and modes 4 or 5 with register 7, give a one-cycle `illegal` with no `done`, no memory request and no register write.
- R11: Mode 1 on a non-PC register gives `opnd_addr` = register value with no register write and no memory request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin address evaluation (taken when idle) |
| mode | input | 3 | Addressing mode 0..7 |
| rsel | input | 3 | Register number (7 = program counter) |
| reg_val | input | 16 | Current value of the selected register |
| pc_val | input | 16 | Current program counter |
| dbl_mode | input | 1 | 1 = double precision (8-byte operands) |
| long_op | input | 1 | 1 = operand is a 32-bit integer |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 16 | Read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data word |
| done | output | 1 | One-cycle pulse: operand location ready |
| illegal | output | 1 | One-cycle pulse: mode/register combination is illegal |
| opnd_addr | output | 16 | Operand byte address |
| opnd_imm | output | 1 | Operand is a one-word immediate |
| opnd_direct | output | 1 | Operand is a register, not memory |
| wb_en | output | 1 | Register write-back strobe (with done) |
| wb_idx | output | 3 | Register to write |
| wb_data | output | 16 | New register value |

## Verification
The bench goes after the step size. If the design mixes up the single, double and long-integer cases, it writes back the wrong autoincrement or predecrement value, for example 8 instead of 4 for a long operand in double mode. It also targets the PC forms. A design that treats a float immediate like an ordinary autoincrement would step the PC by 4 and leave `opnd_imm` clear. A design that treats PC-relative indexing with the old PC would be off by two. Memory latency varies between vectors, so a sequencer that goes on without waiting for `mem_valid`, or that issues the wrong number of reads for modes 3, 5 and 7, is caught. Illegal combinations and a reset during an outstanding read are checked for stray `done` or write-back strobes.

// File: rtl/fop_pkg.sv
package fop_pkg;
  typedef enum logic [1:0] {
    S_IDLE     = 2'd0,
    S_WAIT_IDX = 2'd1,
    S_WAIT_PTR = 2'd2
  } seq_state_t;

  // Classification of one addressing mode/register pair
  typedef struct packed {
    logic direct;     // operand is a register
    logic bad;        // combination not allowed
    logic rd_index;   // fetch displacement word at PC
    logic rd_ptr;     // fetch pointer word
    logic pre_dec;    // step register down before use
    logic post_inc;   // step register up after use
    logic short_imm;  // one-word immediate via PC
  } mode_dec_t;
endpackage

// File: rtl/fop_decode.sv
module fop_decode
  import fop_pkg::*;
#(
  parameter int RW      = 3,
  parameter int NUM_FAC = 6
) (
  input  logic [2:0]    mode,
  input  logic [RW-1:0] rsel,
  input  logic          long_op,
  output mode_dec_t     dec
);
  localparam logic [RW-1:0] PC_IDX = {RW{1'b1}};

  logic is_pc;
  assign is_pc = (rsel == PC_IDX);

  always_comb begin
    dec = '0;
    unique case (mode)
      3'd0: begin
        dec.direct = 1'b1;
        dec.bad    = !long_op && (int'(rsel) >= NUM_FAC);
      end
      3'd1: begin
        dec.short_imm = is_pc && !long_op;
        dec.post_inc  = is_pc && !long_op;
      end
      3'd2: begin
        dec.short_imm = is_pc && !long_op;
        dec.post_inc  = 1'b1;
      end
      3'd3: begin
        dec.short_imm = is_pc && !long_op;
        dec.post_inc  = 1'b1;
        dec.rd_ptr    = 1'b1;
      end
      3'd4: begin
        dec.pre_dec = 1'b1;
        dec.bad     = is_pc;
      end
      3'd5: begin
        dec.pre_dec = 1'b1;
        dec.rd_ptr  = 1'b1;
        dec.bad     = is_pc;
      end
      3'd6: dec.rd_index = 1'b1;
      3'd7: begin
        dec.rd_index = 1'b1;
        dec.rd_ptr   = 1'b1;
      end
      default: dec = '0;
    endcase
  end
endmodule

// File: rtl/fop_step.sv
module fop_step #(
  parameter int AW         = 16,
  parameter int SGL_BYTES  = 4,
  parameter int DBL_BYTES  = 8,
  parameter int WORD_BYTES = 2
) (
  input  logic          dbl_mode,
  input  logic          long_op,
  input  logic          short_imm,
  output logic [AW-1:0] step
);
  always_comb begin
    if (short_imm)                 step = AW'(WORD_BYTES);
    else if (long_op || !dbl_mode) step = AW'(SGL_BYTES);
    else                           step = AW'(DBL_BYTES);
  end
endmodule

// File: rtl/fop_ea_seq.sv
module fop_ea_seq
  import fop_pkg::*;
#(
  parameter int AW         = 16,
  parameter int RW         = 3,
  parameter int NUM_FAC    = 6,
  parameter int SGL_BYTES  = 4,
  parameter int DBL_BYTES  = 8,
  parameter int WORD_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [RW-1:0] rsel,
  input  logic [AW-1:0] reg_val,
  input  logic [AW-1:0] pc_val,
  input  logic          dbl_mode,
  input  logic          long_op,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic          illegal,
  output logic [AW-1:0] opnd_addr,
  output logic          opnd_imm,
  output logic          opnd_direct,
  output logic          wb_en,
  output logic [RW-1:0] wb_idx,
  output logic [AW-1:0] wb_data
);
  localparam logic [RW-1:0] PC_IDX = {RW{1'b1}};

  mode_dec_t     dec;
  logic [AW-1:0] step;
  logic [AW-1:0] pc_next, eff_c, upd_c, idx_sum;
  logic          is_pc;

  fop_decode #(.RW(RW), .NUM_FAC(NUM_FAC)) u_dec (
    .mode(mode), .rsel(rsel), .long_op(long_op), .dec(dec)
  );

  fop_step #(.AW(AW), .SGL_BYTES(SGL_BYTES), .DBL_BYTES(DBL_BYTES),
             .WORD_BYTES(WORD_BYTES)) u_step (
    .dbl_mode(dbl_mode), .long_op(long_op), .short_imm(dec.short_imm), .step(step)
  );

  seq_state_t    st;
  logic          ptr_q, imm_q, pend_wr;
  logic [RW-1:0] pend_idx;
  logic [AW-1:0] pend_data, base_q;

  assign is_pc   = (rsel == PC_IDX);
  assign pc_next = pc_val + AW'(WORD_BYTES);
  assign eff_c   = dec.pre_dec ? (reg_val - step) : reg_val;
  assign upd_c   = dec.pre_dec ? (reg_val - step) : (reg_val + step);
  assign idx_sum = mem_rdata + base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      mem_req     <= 1'b0;
      mem_addr    <= '0;
      done        <= 1'b0;
      illegal     <= 1'b0;
      opnd_addr   <= '0;
      opnd_imm    <= 1'b0;
      opnd_direct <= 1'b0;
      wb_en       <= 1'b0;
      wb_idx      <= '0;
      wb_data     <= '0;
      ptr_q       <= 1'b0;
      imm_q       <= 1'b0;
      pend_wr     <= 1'b0;
      pend_idx    <= '0;
      pend_data   <= '0;
      base_q      <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      mem_req <= 1'b0;
      wb_en   <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          ptr_q <= dec.rd_ptr;
          imm_q <= dec.short_imm;
          if (dec.bad) begin
            illegal <= 1'b1;
          end else if (dec.direct) begin
            done        <= 1'b1;
            opnd_direct <= 1'b1;
            opnd_imm    <= 1'b0;
            opnd_addr   <= '0;
          end else if (dec.rd_index) begin
            mem_req   <= 1'b1;
            mem_addr  <= pc_val;
            pend_wr   <= 1'b1;
            pend_idx  <= PC_IDX;
            pend_data <= pc_next;
            base_q    <= is_pc ? pc_next : reg_val;
            st        <= S_WAIT_IDX;
          end else if (dec.rd_ptr) begin
            mem_req   <= 1'b1;
            mem_addr  <= eff_c;
            pend_wr   <= dec.pre_dec || dec.post_inc;
            pend_idx  <= rsel;
            pend_data <= upd_c;
            st        <= S_WAIT_PTR;
          end else begin
            done        <= 1'b1;
            opnd_direct <= 1'b0;
            opnd_imm    <= dec.short_imm;
            opnd_addr   <= eff_c;
            wb_en       <= dec.pre_dec || dec.post_inc;
            wb_idx      <= rsel;
            wb_data     <= upd_c;
          end
        end
        S_WAIT_IDX: if (mem_valid) begin
          if (ptr_q) begin
            mem_req  <= 1'b1;
            mem_addr <= idx_sum;
            st       <= S_WAIT_PTR;
          end else begin
            done        <= 1'b1;
            opnd_direct <= 1'b0;
            opnd_imm    <= 1'b0;
            opnd_addr   <= idx_sum;
            wb_en       <= pend_wr;
            wb_idx      <= pend_idx;
            wb_data     <= pend_data;
            st          <= S_IDLE;
          end
        end
        S_WAIT_PTR: if (mem_valid) begin
          done        <= 1'b1;
          opnd_direct <= 1'b0;
          opnd_imm    <= imm_q;
          opnd_addr   <= mem_rdata;
          wb_en       <= pend_wr;
          wb_idx      <= pend_idx;
          wb_data     <= pend_data;
          st          <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R9
  AST_WB_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> done); // R9
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!done && !wb_en && !mem_req)); // R10
  AST_IMM_STEPS_PC: assert property (@(posedge clk) disable iff (rst)
    (done && opnd_imm) |-> (wb_en && wb_idx == PC_IDX)); // R4
  AST_DIRECT_NO_WB: assert property (@(posedge clk) disable iff (rst)
    (done && opnd_direct) |-> (!wb_en && !opnd_imm)); // R2
endmodule

// File: tb/fop_ea_seq_tb.sv
module fop_ea_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [2:0]  rsel = '0;
  logic [15:0] reg_val = '0;
  logic [15:0] pc_val = '0;
  logic        dbl_mode = 1'b0;
  logic        long_op = 1'b0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        done, illegal, opnd_imm, opnd_direct, wb_en;
  logic [15:0] opnd_addr, wb_data;
  logic [2:0]  wb_idx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int mem_lat = 0;

  always #10 clk = ~clk;  // 50 MHz

  fop_ea_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .rsel(rsel),
    .reg_val(reg_val), .pc_val(pc_val), .dbl_mode(dbl_mode), .long_op(long_op),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .done(done), .illegal(illegal),
    .opnd_addr(opnd_addr), .opnd_imm(opnd_imm), .opnd_direct(opnd_direct),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  // Memory model: word at address A reads as A + 0x0100
  logic        pend = 1'b0;
  logic [15:0] paddr = '0;
  int          pcnt = 0;
  always @(negedge clk) begin
    mem_valid = 1'b0;
    if (rst) begin
      pend = 1'b0;
    end else begin
      if (pend) begin
        if (pcnt == 0) begin
          mem_valid = 1'b1;
          mem_rdata = paddr + 16'h0100;
          pend = 1'b0;
        end else pcnt--;
      end
      if (mem_req) begin
        pend = 1'b1;
        paddr = mem_addr;
        pcnt = mem_lat;
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R9 watchdog expired: actual %0d cycles expected fewer", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  mode;
    logic [2:0]  rsel;
    logic        lng;
    logic        dbl;
    logic [15:0] rv;
    logic [15:0] pc;
    logic [15:0] addr;
    logic        imm;
    logic        dir;
    logic        wr;
    logic [2:0]  idx;
    logic [15:0] wd;
    logic        ill;
    logic [1:0]  nrd;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{3'd0,3'd2,1'b0,1'b0,16'h1111,16'h0100,16'h0000,1'b0,1'b1,1'b0,3'd0,16'h0000,1'b0,2'd0}, // R2
    '{3'd0,3'd7,1'b0,1'b0,16'h1111,16'h0100,16'h0000,1'b0,1'b0,1'b0,3'd0,16'h0000,1'b1,2'd0}, // R10
    '{3'd0,3'd6,1'b1,1'b0,16'h1111,16'h0100,16'h0000,1'b0,1'b1,1'b0,3'd0,16'h0000,1'b0,2'd0}, // R2 long
    '{3'd1,3'd3,1'b0,1'b0,16'h2000,16'h0100,16'h2000,1'b0,1'b0,1'b0,3'd0,16'h0000,1'b0,2'd0}, // R11
    '{3'd2,3'd1,1'b0,1'b0,16'h3000,16'h0100,16'h3000,1'b0,1'b0,1'b1,3'd1,16'h3004,1'b0,2'd0}, // R3
    '{3'd2,3'd1,1'b0,1'b1,16'h3000,16'h0100,16'h3000,1'b0,1'b0,1'b1,3'd1,16'h3008,1'b0,2'd0}, // R3
    '{3'd2,3'd1,1'b1,1'b1,16'h3000,16'h0100,16'h3000,1'b0,1'b0,1'b1,3'd1,16'h3004,1'b0,2'd0}, // R8
    '{3'd2,3'd7,1'b0,1'b1,16'h0400,16'h0400,16'h0400,1'b1,1'b0,1'b1,3'd7,16'h0402,1'b0,2'd0}, // R4
    '{3'd1,3'd7,1'b0,1'b0,16'h0500,16'h0500,16'h0500,1'b1,1'b0,1'b1,3'd7,16'h0502,1'b0,2'd0}, // R4
    '{3'd3,3'd7,1'b0,1'b1,16'h0600,16'h0600,16'h0700,1'b1,1'b0,1'b1,3'd7,16'h0602,1'b0,2'd1}, // R4
    '{3'd3,3'd4,1'b0,1'b1,16'h1200,16'h0100,16'h1300,1'b0,1'b0,1'b1,3'd4,16'h1208,1'b0,2'd1}, // R7
    '{3'd4,3'd5,1'b0,1'b1,16'h2010,16'h0100,16'h2008,1'b0,1'b0,1'b1,3'd5,16'h2008,1'b0,2'd0}, // R5
    '{3'd4,3'd5,1'b0,1'b0,16'h2010,16'h0100,16'h200C,1'b0,1'b0,1'b1,3'd5,16'h200C,1'b0,2'd0}, // R5
    '{3'd5,3'd2,1'b0,1'b0,16'h4000,16'h0100,16'h40FC,1'b0,1'b0,1'b1,3'd2,16'h3FFC,1'b0,2'd1}, // R5
    '{3'd5,3'd2,1'b1,1'b1,16'h4000,16'h0100,16'h40FC,1'b0,1'b0,1'b1,3'd2,16'h3FFC,1'b0,2'd1}, // R8
    '{3'd4,3'd7,1'b0,1'b0,16'h0900,16'h0900,16'h0000,1'b0,1'b0,1'b0,3'd0,16'h0000,1'b1,2'd0}, // R10
    '{3'd5,3'd7,1'b0,1'b1,16'h0900,16'h0900,16'h0000,1'b0,1'b0,1'b0,3'd0,16'h0000,1'b1,2'd0}, // R10
    '{3'd6,3'd3,1'b0,1'b0,16'h1000,16'h0800,16'h1900,1'b0,1'b0,1'b1,3'd7,16'h0802,1'b0,2'd1}, // R6
    '{3'd6,3'd7,1'b0,1'b0,16'h0800,16'h0800,16'h1102,1'b0,1'b0,1'b1,3'd7,16'h0802,1'b0,2'd1}, // R6
    '{3'd7,3'd3,1'b0,1'b1,16'h1000,16'h0800,16'h1A00,1'b0,1'b0,1'b1,3'd7,16'h0802,1'b0,2'd2}, // R6
    '{3'd4,3'd1,1'b1,1'b1,16'h2000,16'h0100,16'h1FFC,1'b0,1'b0,1'b1,3'd1,16'h1FFC,1'b0,2'd0}, // R8
    '{3'd3,3'd4,1'b1,1'b1,16'h1200,16'h0100,16'h1300,1'b0,1'b0,1'b1,3'd4,16'h1204,1'b0,2'd1}, // R8
    '{3'd3,3'd7,1'b1,1'b0,16'h0600,16'h0600,16'h0700,1'b0,1'b0,1'b1,3'd7,16'h0604,1'b0,2'd1}  // R8
  };

  task automatic run_vec(input int i);
    vec_t v;
    int   cyc;
    int   reqs;
    logic got;
    logic saw_done;
    string tag;
    v = VEC[i];
    tag = $sformatf("vec%0d", i);
    mem_lat = i % 3;
    mode = v.mode; rsel = v.rsel; long_op = v.lng; dbl_mode = v.dbl;
    reg_val = v.rv; pc_val = v.pc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; reqs = 0; got = 1'b0; saw_done = 1'b0;
    while (cyc < 60 && !got) begin
      if (mem_req) reqs++;
      if (done || illegal) begin
        got = 1'b1;
        saw_done = done;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    chk("R9", {tag, " completed"}, 32'(got), 32'd1);
    chk("R9", {tag, " read count"}, 32'(reqs), 32'(v.nrd));
    if (v.ill) begin
      chk("R10", {tag, " illegal strobe"}, {illegal, saw_done, wb_en}, 32'b100);
    end else begin
      chk("R9", {tag, " done strobe"}, {illegal, saw_done}, 32'b01);
      chk("R3", {tag, " operand address"}, 32'(opnd_addr), 32'(v.addr));
      chk("R4", {tag, " immediate flag"}, 32'(opnd_imm), 32'(v.imm));
      chk("R2", {tag, " direct flag"}, 32'(opnd_direct), 32'(v.dir));
      chk("R5", {tag, " write strobe"}, 32'(wb_en), 32'(v.wr));
      if (v.wr) begin
        chk("R6", {tag, " write index"}, 32'(wb_idx), 32'(v.idx));
        chk("R8", {tag, " write data"}, 32'(wb_data), 32'(v.wd));
      end
      if (v.nrd == 2'd0) chk("R2", {tag, " latency"}, 32'(cyc), 32'd1);
    end
    @(negedge clk);
    chk("R9", {tag, " strobes one cycle"}, {done, illegal, wb_en}, 32'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset outputs", {done, illegal, mem_req, wb_en}, 32'b0000);
    for (int i = 0; i < NV; i++) run_vec(i);

    // R1: reset while a mode 7 read is outstanding
    mem_lat = 5;
    mode = 3'd7; rsel = 3'd2; reg_val = 16'h1000; pc_val = 16'h0800;
    long_op = 1'b0; dbl_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "mid-op request issued", 32'(mem_req), 32'd1);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "reset mid-operation", {done, illegal, mem_req, wb_en}, 32'b0000);
    rst = 1'b0;
    repeat (10) begin
      @(negedge clk);
      chk("R1", "quiet after reset", {done, illegal, mem_req, wb_en}, 32'b0000);
    end
    // R11: block still works after the abort
    mem_lat = 0;
    run_vec(3);
    summary();
    $finish;
  end
endmodule